// File: doc/BRIEF.md
# Substitution-Permutation Bit Scrambler

The block is a keyed, invertible bit scrambler of configurable width, used to hide the layout of ROM address and data words. It takes a data word and a key word of equal width and a mode bit, and gives back the scrambled word (mode low) or the unscrambled word (mode high) one clock later. For a fixed key the mapping is a permutation of the word space, and the two modes undo each other exactly. That lets a build tool store a scrambled image while the read path recovers the clear data.

In the forward direction, each round first mixes in the key. It then replaces every 4-bit group with a fixed substitution, mirrors the whole word end to end, and finally splits the even and odd bit positions into the lower and upper halves. The inverse direction runs the mirrored steps in reverse order with the inverse substitution. Both directions finish with one more key XOR after the last round. Widths that are odd, or that are not a multiple of four, are supported: the spare bits skip the steps that cannot cover them.

Top module: `sp_scrambler`

## Requirements
- R1: The forward substitution maps each 4-bit group, for inputs 0 to 15, to C,5,6,B,9,0,A,D,3,E,F,8,4,7,1,2 (hex). With WIDTH=4, ROUNDS=1, key 0 and forward mode, the output is that value with bits 0 and 3 swapped.
- R2: The inverse substitution maps inputs 0 to 15 to 5,E,F,8,C,1,2,D,B,4,6,3,0,7,9,A. With WIDTH=4, ROUNDS=1, key 0 and inverse mode, the output is the inverse substitution of the input with bits 0 and 3 swapped.
- R3: A forward round applies these steps in order: XOR with the key, substitution on 4-bit groups starting at bit 0, then a mirror in which bit i moves to bit WIDTH-1-i, then a shuffle.
- R4: The forward shuffle moves bit 2i to bit i and bit 2i+1 to bit WIDTH/2+i, for i < WIDTH/2. When WIDTH is odd, the top bit keeps its position.
- R5: After the last round the state is XORed with the key once more before output.
- R6: An inverse round applies these steps in order: key XOR, unshuffle (bit i to 2i, bit WIDTH/2+i to 2i+1), mirror, inverse substitution. Inverse mode applied to a forward result with the same key returns the original word.
- R7: When WIDTH is not a multiple of 4, the WIDTH mod 4 top bits bypass the substitution step unchanged.
- R8: The number of rounds is a parameter with default 2.
- R9: The output is registered: it reflects the inputs sampled at the previous rising clock edge, holds while the inputs hold, and is all zeros while reset is asserted.
- R10: For a fixed key and mode, distinct inputs give distinct outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| decrypt_i | input | 1 | 0 scrambles, 1 unscrambles |
| data_i | input | WIDTH | Word to transform |
| key_i | input | WIDTH | Round key, also used for the final XOR |
| data_o | output | WIDTH | Transformed word, one cycle after the inputs |

## Verification
On every cycle the assertions check three things. First, a separate core in the opposite mode undoes the registered output back to the previous input. Second, a changed input under an unchanged key and mode gives a changed output. Third, the output holds for held inputs and is zero when reset is released. The exact substitution tables, the bit order of the mirror and shuffle, the bypass of spare bits and the round count only show up in the bench: it sweeps all 4-bit and 13-bit words against an arithmetic model, and it sends random 39-bit words through both modes.

// File: rtl/sp_scr_pkg.sv
package sp_scr_pkg;

  function automatic logic [3:0] sbox_fwd(input logic [3:0] x);
    logic [3:0] y;
    case (x)
      4'h0: y = 4'hc;  4'h1: y = 4'h5;  4'h2: y = 4'h6;  4'h3: y = 4'hb;
      4'h4: y = 4'h9;  4'h5: y = 4'h0;  4'h6: y = 4'ha;  4'h7: y = 4'hd;
      4'h8: y = 4'h3;  4'h9: y = 4'he;  4'ha: y = 4'hf;  4'hb: y = 4'h8;
      4'hc: y = 4'h4;  4'hd: y = 4'h7;  4'he: y = 4'h1;  default: y = 4'h2;
    endcase
    return y;
  endfunction

  function automatic logic [3:0] sbox_inv(input logic [3:0] x);
    logic [3:0] y;
    case (x)
      4'h0: y = 4'h5;  4'h1: y = 4'he;  4'h2: y = 4'hf;  4'h3: y = 4'h8;
      4'h4: y = 4'hc;  4'h5: y = 4'h1;  4'h6: y = 4'h2;  4'h7: y = 4'hd;
      4'h8: y = 4'hb;  4'h9: y = 4'h4;  4'ha: y = 4'h6;  4'hb: y = 4'h3;
      4'hc: y = 4'h0;  4'hd: y = 4'h7;  4'he: y = 4'h9;  default: y = 4'ha;
    endcase
    return y;
  endfunction

endpackage

// File: rtl/sp_sbox_layer.sv
module sp_sbox_layer #(
  parameter int WIDTH   = 16,
  parameter bit INVERSE = 1'b0
) (
  input  logic [WIDTH-1:0] x_i,
  output logic [WIDTH-1:0] y_o
);
  import sp_scr_pkg::*;

  localparam int NIB = WIDTH / 4;
  localparam int REM = WIDTH - 4 * NIB;

  for (genvar n = 0; n < NIB; n++) begin : g_nib
    if (INVERSE) begin : g_inv
      assign y_o[4*n +: 4] = sbox_inv(x_i[4*n +: 4]);
    end else begin : g_fwd
      assign y_o[4*n +: 4] = sbox_fwd(x_i[4*n +: 4]);
    end
  end

  // spare top bits skip substitution
  if (REM > 0) begin : g_rem
    assign y_o[WIDTH-1:4*NIB] = x_i[WIDTH-1:4*NIB];
  end

endmodule

// File: rtl/sp_perm_layer.sv
module sp_perm_layer #(
  parameter int WIDTH   = 16,
  parameter bit INVERSE = 1'b0
) (
  input  logic [WIDTH-1:0] x_i,
  output logic [WIDTH-1:0] y_o
);
  localparam int HALF = WIDTH / 2;

  if (!INVERSE) begin : g_fwd
    logic [WIDTH-1:0] rev;
    always_comb begin
      for (int i = 0; i < WIDTH; i++) rev[i] = x_i[WIDTH-1-i];
    end
    always_comb begin
      y_o = rev;  // odd width: top bit stays
      for (int i = 0; i < HALF; i++) begin
        y_o[i]      = rev[2*i];
        y_o[HALF+i] = rev[2*i+1];
      end
    end
  end else begin : g_inv
    logic [WIDTH-1:0] bfly;
    always_comb begin
      bfly = x_i;
      for (int i = 0; i < HALF; i++) begin
        bfly[2*i]   = x_i[i];
        bfly[2*i+1] = x_i[HALF+i];
      end
    end
    always_comb begin
      for (int i = 0; i < WIDTH; i++) y_o[i] = bfly[WIDTH-1-i];
    end
  end

endmodule

// File: rtl/sp_round.sv
module sp_round #(
  parameter int WIDTH   = 16,
  parameter bit INVERSE = 1'b0
) (
  input  logic [WIDTH-1:0] state_i,
  input  logic [WIDTH-1:0] key_i,
  output logic [WIDTH-1:0] state_o
);
  logic [WIDTH-1:0] mixed;
  logic [WIDTH-1:0] mid;

  assign mixed = state_i ^ key_i;

  if (!INVERSE) begin : g_fwd
    sp_sbox_layer #(.WIDTH(WIDTH), .INVERSE(1'b0)) i_sbox (.x_i(mixed), .y_o(mid));
    sp_perm_layer #(.WIDTH(WIDTH), .INVERSE(1'b0)) i_perm (.x_i(mid),   .y_o(state_o));
  end else begin : g_inv
    sp_perm_layer #(.WIDTH(WIDTH), .INVERSE(1'b1)) i_perm (.x_i(mixed), .y_o(mid));
    sp_sbox_layer #(.WIDTH(WIDTH), .INVERSE(1'b1)) i_sbox (.x_i(mid),   .y_o(state_o));
  end

endmodule

// File: rtl/sp_core.sv
module sp_core #(
  parameter int WIDTH  = 16,
  parameter int ROUNDS = 2
) (
  input  logic             decrypt_i,
  input  logic [WIDTH-1:0] data_i,
  input  logic [WIDTH-1:0] key_i,
  output logic [WIDTH-1:0] data_o
);
  logic [WIDTH-1:0] enc_st [ROUNDS+1];
  logic [WIDTH-1:0] dec_st [ROUNDS+1];

  assign enc_st[0] = data_i;
  assign dec_st[0] = data_i;

  for (genvar r = 0; r < ROUNDS; r++) begin : g_rnd
    sp_round #(.WIDTH(WIDTH), .INVERSE(1'b0)) i_enc (
      .state_i(enc_st[r]), .key_i(key_i), .state_o(enc_st[r+1])
    );
    sp_round #(.WIDTH(WIDTH), .INVERSE(1'b1)) i_dec (
      .state_i(dec_st[r]), .key_i(key_i), .state_o(dec_st[r+1])
    );
  end

  assign data_o = (decrypt_i ? dec_st[ROUNDS] : enc_st[ROUNDS]) ^ key_i;

endmodule

// File: rtl/sp_scrambler.sv
module sp_scrambler #(
  parameter int WIDTH  = 16,
  parameter int ROUNDS = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             decrypt_i,
  input  logic [WIDTH-1:0] data_i,
  input  logic [WIDTH-1:0] key_i,
  output logic [WIDTH-1:0] data_o
);
  logic [WIDTH-1:0] core_out;

  sp_core #(.WIDTH(WIDTH), .ROUNDS(ROUNDS)) i_core (
    .decrypt_i(decrypt_i),
    .data_i   (data_i),
    .key_i    (key_i),
    .data_o   (core_out)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) data_o <= '0;
    else         data_o <= core_out;
  end

endmodule

// File: rtl/sp_scrambler_chk.sv
module sp_scrambler_chk #(
  parameter int WIDTH  = 16,
  parameter int ROUNDS = 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             decrypt_i,
  input logic [WIDTH-1:0] data_i,
  input logic [WIDTH-1:0] key_i,
  input logic [WIDTH-1:0] data_o
);
  logic [1:0]       seen;
  logic             p_dec;
  logic [WIDTH-1:0] p_data;
  logic [WIDTH-1:0] p_key;
  logic [WIDTH-1:0] undone;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen   <= '0;
      p_dec  <= 1'b0;
      p_data <= '0;
      p_key  <= '0;
    end else begin
      if (seen != 2'd3) seen <= seen + 2'd1;
      p_dec  <= decrypt_i;
      p_data <= data_i;
      p_key  <= key_i;
    end
  end

  // opposite-mode core undoes the registered result
  sp_core #(.WIDTH(WIDTH), .ROUNDS(ROUNDS)) i_undo (
    .decrypt_i(!p_dec),
    .data_i   (data_o),
    .key_i    (p_key),
    .data_o   (undone)
  );

  AST_ROUND_TRIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen != 2'd0) |-> (undone == p_data)); // R6

  AST_RESET_ZERO: assert property (@(posedge clk_i)
    $rose(rst_ni) |-> (data_o == '0)); // R9

  AST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((seen != 2'd0) && data_i == p_data && key_i == p_key && decrypt_i == p_dec)
    |=> $stable(data_o)); // R9

  AST_BIJECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((seen != 2'd0) && key_i == p_key && decrypt_i == p_dec && data_i != p_data)
    |=> (data_o != $past(data_o))); // R10

endmodule

bind sp_scrambler sp_scrambler_chk #(.WIDTH(WIDTH), .ROUNDS(ROUNDS)) i_sp_scrambler_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .decrypt_i(decrypt_i),
  .data_i   (data_i),
  .key_i    (key_i),
  .data_o   (data_o)
);

// File: tb/test_sp_scrambler.sv
module test_sp_scrambler;

  localparam logic [3:0] FWD_T [16] = '{4'hc, 4'h5, 4'h6, 4'hb, 4'h9, 4'h0, 4'ha, 4'hd,
                                        4'h3, 4'he, 4'hf, 4'h8, 4'h4, 4'h7, 4'h1, 4'h2};
  localparam logic [3:0] INV_T [16] = '{4'h5, 4'he, 4'hf, 4'h8, 4'hc, 4'h1, 4'h2, 4'hd,
                                        4'hb, 4'h4, 4'h6, 4'h3, 4'h0, 4'h7, 4'h9, 4'ha};

  logic clk;
  logic rst_ni;
  int   n_tests;
  int   n_fail;
  bit   done;

  logic        dec4,  dec13, dec39;
  logic [3:0]  d4,  k4,  q4;
  logic [12:0] d13, k13, q13;
  logic [38:0] d39, k39, q39;

  initial clk = 1'b0;
  always #5 clk = ~clk;

  sp_scrambler #(.WIDTH(13)) i_sp_scrambler (
    .clk_i(clk), .rst_ni(rst_ni), .decrypt_i(dec13), .data_i(d13), .key_i(k13), .data_o(q13)
  );
  sp_scrambler #(.WIDTH(39)) i_sp_scrambler_w39 (
    .clk_i(clk), .rst_ni(rst_ni), .decrypt_i(dec39), .data_i(d39), .key_i(k39), .data_o(q39)
  );
  sp_scrambler #(.WIDTH(4), .ROUNDS(1)) i_sp_scrambler_w4 (
    .clk_i(clk), .rst_ni(rst_ni), .decrypt_i(dec4), .data_i(d4), .key_i(k4), .data_o(q4)
  );

  function automatic logic [63:0] m_sbox(logic [63:0] v, int w, bit inv);
    logic [63:0] r = v;
    for (int n = 0; n < w / 4; n++) r[4*n +: 4] = inv ? INV_T[v[4*n +: 4]] : FWD_T[v[4*n +: 4]];
    return r;
  endfunction

  function automatic logic [63:0] m_rev(logic [63:0] v, int w);
    logic [63:0] r = '0;
    for (int i = 0; i < w; i++) r[w-1-i] = v[i];
    return r;
  endfunction

  function automatic logic [63:0] m_bfly(logic [63:0] v, int w);
    logic [63:0] r = v;
    for (int i = 0; i < w / 2; i++) begin
      r[i] = v[2*i];
      r[w/2+i] = v[2*i+1];
    end
    return r;
  endfunction

  function automatic logic [63:0] m_ibfly(logic [63:0] v, int w);
    logic [63:0] r = v;
    for (int i = 0; i < w / 2; i++) begin
      r[2*i] = v[i];
      r[2*i+1] = v[w/2+i];
    end
    return r;
  endfunction

  function automatic logic [63:0] m_enc(logic [63:0] d, logic [63:0] k, int w, int rn);
    for (int r = 0; r < rn; r++) d = m_bfly(m_rev(m_sbox(d ^ k, w, 1'b0), w), w);
    return d ^ k;
  endfunction

  function automatic logic [63:0] m_dec(logic [63:0] d, logic [63:0] k, int w, int rn);
    for (int r = 0; r < rn; r++) d = m_sbox(m_rev(m_ibfly(d ^ k, w), w), w, 1'b1);
    return d ^ k;
  endfunction

  function automatic logic [3:0] swap03(logic [3:0] v);
    return {v[0], v[2], v[1], v[3]};
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
    end
  end

  initial begin
    bit seen13 [8192];
    logic [12:0] y13, prev13;
    logic [38:0] x39, y39;
    n_tests = 0; n_fail = 0; done = 1'b0;
    rst_ni = 1'b0;
    dec4 = 1'b0; d4 = 4'h7; k4 = 4'h0;
    dec13 = 1'b0; d13 = 13'h1abc; k13 = 13'h0f0f;
    dec39 = 1'b0; d39 = 39'h12_3456_789a; k39 = 39'h55_aaaa_5555;
    repeat (3) @(posedge clk);
    #1;
    // R9: reset state
    check("R9 reset w13", 64'(q13), 64'h0);
    check("R9 reset w39", 64'(q39), 64'h0);
    check("R9 reset w4",  64'(q4),  64'h0);
    rst_ni = 1'b1;

    // R1 / R2: tables through a 1-round 4-bit instance with zero key
    for (int x = 0; x < 16; x++) begin
      dec4 = 1'b0; d4 = 4'(x); cyc();
      check("R1 fwd sbox", 64'(q4), 64'(swap03(FWD_T[x])));
    end
    for (int x = 0; x < 16; x++) begin
      dec4 = 1'b1; d4 = 4'(x); cyc();
      check("R2 inv sbox", 64'(q4), 64'(INV_T[swap03(4'(x))]));
    end

    // R3 R4 R5 R7 R8 R10: exhaustive 13-bit forward sweep, default rounds
    dec13 = 1'b0; k13 = 13'h1a5c;
    for (int x = 0; x < 8192; x++) begin
      d13 = 13'(x); cyc();
      check("R3/R4/R5/R7/R8 w13 fwd", 64'(q13), m_enc(64'(x), 64'(k13), 13, 2));
      if (seen13[q13]) check("R10 w13 collision", 64'(q13), 64'hffff_ffff_ffff_ffff);
      seen13[q13] = 1'b1;
    end

    // R6: exhaustive 13-bit inverse sweep against model
    dec13 = 1'b1; k13 = 13'h0763;
    for (int x = 0; x < 8192; x++) begin
      d13 = 13'(x); cyc();
      check("R6 w13 inv", 64'(q13), m_dec(64'(x), 64'(k13), 13, 2));
    end

    // R6: round trip through the design at width 13
    for (int t = 0; t < 1500; t++) begin
      k13 = 13'($urandom); d13 = 13'($urandom); dec13 = 1'b0; cyc();
      y13 = q13; d13 = y13; dec13 = 1'b1; prev13 = 13'(m_enc(64'(y13), 64'(k13), 13, 0) ^ 64'(k13));
      cyc();
      check("R6 w13 round trip", 64'(q13), 64'(m_dec(64'(y13), 64'(k13), 13, 2)));
      check("R6 w13 inverse of fwd", 64'(m_enc(64'(q13), 64'(k13), 13, 2)), 64'(y13));
      if (prev13 != y13) check("R5 model sanity", 64'(prev13), 64'(y13));
    end

    // R4 R7: 39-bit (odd, 3 spare bits) random words, both modes and round trip
    for (int t = 0; t < 2000; t++) begin
      x39 = {$urandom, $urandom} & 39'h7f_ffff_ffff;
      k39 = {$urandom, $urandom} & 39'h7f_ffff_ffff;
      d39 = x39; dec39 = 1'b0; cyc();
      check("R4/R7 w39 fwd", 64'(q39), m_enc(64'(x39), 64'(k39), 39, 2));
      y39 = q39; d39 = y39; dec39 = 1'b1; cyc();
      check("R6 w39 round trip", 64'(q39), 64'(x39));
    end

    // R9: output changes only at a clock edge, and holds with held inputs
    dec13 = 1'b0; k13 = 13'h0abc; d13 = 13'h0123; cyc();
    y13 = q13;
    d13 = 13'h1321; #2;
    check("R9 no change before edge", 64'(q13), 64'(y13));
    cyc();
    check("R9 one-cycle latency", 64'(q13), m_enc(64'h1321, 64'h0abc, 13, 2));
    y13 = q13; cyc(); cyc();
    check("R9 hold", 64'(q13), 64'(y13));

    done = 1'b1;
    finish_run();
  end

endmodule